// File: doc/BRIEF.md
# Interleaved Multi-Accumulator Sum Reducer

This block totals a stream of integer operands using an adder whose result only returns several cycles after the operands go in. A single running total would stall every beat until the previous sum came back, so the block keeps a set of independent partial sums instead. There are as many of them as the adder latency multiplied by the number of operands per beat. Each input beat carries one operand per lane. The beat is sent to the next group of partials in a fixed rotation. By the time the rotation returns to a group, that group's earlier sum has already been written back, so the stream is never stalled.

Once the beat flagged as last has been accepted, the input closes. The block then folds the partials together in a binary tree. Each level of the tree waits for the adder pipeline to empty before the next level starts. The total is then offered as a single result beat. Arithmetic wraps modulo two to the data width. When the result is taken, the partials clear and the input reopens for the next stream.

Top module: `red_sum_interleave`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `out_sum` equals the sum of every operand of every accepted beat, up to and including the beat with `in_last`=1. Lane l of a beat is bits [l*DATA_W +: DATA_W] of `in_ops`. Cycles with `in_valid`=0 inside a stream add nothing.
- R3: While a stream is open, an accepted beat without `in_last` is always followed by `in_ready`=1. One beat per cycle is sustained even though the adder latency is 4 cycles.
- R4: A stream of any length of 1 or more beats gives the correct total, including lengths that are not a multiple of the rotation period. The rotation restarts at partial 0 for each new stream.
- R5: From the cycle after the last beat is accepted until the result handshake, `in_ready` is 0. Any `in_valid` activity during that interval has no effect on the result.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_sum` holds its value.
- R7: In the cycle after the result handshake, `out_valid` is 0 and `in_ready` is 1. All partials are cleared, so the next total does not include the previous stream.
- R8: Sums wrap modulo 2^DATA_W.
- R9: With the default parameters (latency 4, 2 lanes, 8 partials), `out_valid` rises 20 clock edges after the edge that accepts the last beat. That is 4 cycles to drain, 3 tree levels of 4 cycles each, and 4 issue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| in_last | input | 1 | Beat closes the stream |
| in_ops | input | LANES*DATA_W | One operand per lane |
| out_valid | output | 1 | Total available |
| out_ready | input | 1 | Consumer takes the total |
| out_sum | output | DATA_W | Reduced total |

## Verification
The bench drives streams one beat long and streams whose length is not a multiple of the four-beat rotation. A design that did not restart the rotation, or that dropped a partial, would return a wrong total on these. Operand values near the top of the range check the modulo wrap, and streams with idle gaps check that a missing beat adds nothing. During the combine phase the bench keeps presenting junk beats and checks that the block neither takes them nor lets them change the total. The bench also holds back the result to check that the result beat stays stable. Back-to-back streams check the clear: a bank that kept its old partials would add the previous total into the next one. The exact latency from the last beat to the result is checked as well, which catches a tree level that starts before the adder pipeline has written back its results.

// File: rtl/red_pkg.sv
package red_pkg;
   typedef enum logic [1:0] {
      ST_ACC  = 2'd0,
      ST_WAIT = 2'd1,
      ST_TREE = 2'd2,
      ST_OUT  = 2'd3
   } red_state_e;
endpackage

// File: rtl/red_lane_pipe.sv
// One adder lane: the sum is formed on entry and carried through STAGES
// registers; the accumulator write that follows is the final latency cycle.
module red_lane_pipe #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3,
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [IDX_W-1:0]  iss_idx,
   input  logic [DATA_W-1:0] iss_a,
   input  logic [DATA_W-1:0] iss_b,
   output logic              wb_valid,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              busy
);
   logic [STAGES-1:0] v_q;
   logic [IDX_W-1:0]  idx_q [STAGES];
   logic [DATA_W-1:0] dat_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[0] <= 1'b0;
      else        v_q[0] <= iss_valid;
   end

   always_ff @(posedge clk) begin
      idx_q[0] <= iss_idx;
      dat_q[0] <= iss_a + iss_b;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q[s] <= 1'b0;
            else        v_q[s] <= v_q[s-1];
         end
         always_ff @(posedge clk) begin
            idx_q[s] <= idx_q[s-1];
            dat_q[s] <= dat_q[s-1];
         end
      end
   endgenerate

   assign wb_valid = v_q[STAGES-1];
   assign wb_idx   = idx_q[STAGES-1];
   assign wb_data  = dat_q[STAGES-1];
   assign busy     = |v_q;
endmodule

// File: rtl/red_acc_bank.sv
// Partial-sum registers, written back by any lane, cleared on result handshake.
module red_acc_bank #(
   parameter int DATA_W = 32,
   parameter int NACC   = 8,
   parameter int LANES  = 2,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [LANES-1:0]  wb_valid,
   input  logic [IDX_W-1:0]  wb_idx  [LANES],
   input  logic [DATA_W-1:0] wb_data [LANES],
   output logic [DATA_W-1:0] acc_q   [NACC]
);
   generate
      for (genvar a = 0; a < NACC; a++) begin : g_acc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q[a] <= '0;
            end else if (clr) begin
               acc_q[a] <= '0;
            end else begin
               for (int l = 0; l < LANES; l++) begin
                  if (wb_valid[l] && (wb_idx[l] == IDX_W'(a)))
                     acc_q[a] <= wb_data[l];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/red_sum_interleave.sv
module red_sum_interleave
   import red_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LAT    = 4,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic                    in_last,
   input  logic [LANES*DATA_W-1:0] in_ops,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [DATA_W-1:0]       out_sum
);
   localparam int NACC   = LAT * LANES;
   localparam int LVLS   = $clog2(NACC);
   localparam int IDX_W  = (NACC > 1) ? $clog2(NACC) : 1;
   localparam int LVL_W  = $clog2(LVLS + 1);
   localparam int PTR_W  = (LAT > 1) ? $clog2(LAT) : 1;
   localparam int CNT_W  = IDX_W + 1;
   localparam int STAGES = LAT - 1;

   generate
      if (LAT < 2) begin : g_bad_lat
         $error("red_sum_interleave: LAT must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("red_sum_interleave: LANES must be at least 1");
      end
      if ((NACC < 2) || ((NACC & (NACC - 1)) != 0)) begin : g_bad_nacc
         $error("red_sum_interleave: LAT*LANES must be a power of two >= 2");
      end
   endgenerate

   red_state_e        state;
   logic [PTR_W-1:0]  ptr;
   logic [LVL_W-1:0]  lvl;
   logic [CNT_W-1:0]  idx;
   int                nadds;
   logic              accept;
   logic              busy;

   logic [LANES-1:0]  iss_v;
   logic [IDX_W-1:0]  iss_i [LANES];
   logic [DATA_W-1:0] iss_a [LANES];
   logic [DATA_W-1:0] iss_b [LANES];
   logic [LANES-1:0]  wb_v;
   logic [IDX_W-1:0]  wb_i  [LANES];
   logic [DATA_W-1:0] wb_d  [LANES];
   logic [LANES-1:0]  lane_busy;
   logic [DATA_W-1:0] acc_q [NACC];

   assign in_ready  = (state == ST_ACC);
   assign out_valid = (state == ST_OUT);
   assign accept    = in_valid && in_ready;
   assign busy      = |lane_busy;
   assign out_sum   = acc_q[0];

   always_comb nadds = NACC >> (int'(lvl) + 1);

   // Operand steering: stream beats rotate over lane groups, tree levels
   // pair partials at stride 2^lvl.
   always_comb begin
      int j;
      int dst;
      int src;
      for (int l = 0; l < LANES; l++) begin
         j        = 0;
         dst      = 0;
         src      = 0;
         iss_v[l] = 1'b0;
         iss_i[l] = '0;
         iss_a[l] = '0;
         iss_b[l] = '0;
         case (state)
            ST_ACC: begin
               dst      = int'(ptr) * LANES + l;
               iss_v[l] = accept;
               iss_i[l] = IDX_W'(dst);
               iss_a[l] = acc_q[IDX_W'(dst)];
               iss_b[l] = in_ops[l*DATA_W +: DATA_W];
            end
            ST_TREE: begin
               j        = int'(idx) + l;
               dst      = j << (int'(lvl) + 1);
               src      = dst + (1 << int'(lvl));
               iss_v[l] = (j < nadds);
               iss_i[l] = IDX_W'(dst);
               iss_a[l] = acc_q[IDX_W'(dst)];
               iss_b[l] = acc_q[IDX_W'(src)];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_ACC;
         ptr   <= '0;
         lvl   <= '0;
         idx   <= '0;
      end else begin
         case (state)
            ST_ACC: begin
               if (accept) begin
                  if (in_last) begin
                     state <= ST_WAIT;
                     ptr   <= '0;
                     lvl   <= '0;
                     idx   <= '0;
                  end else if (ptr == PTR_W'(LAT - 1)) begin
                     ptr <= '0;
                  end else begin
                     ptr <= ptr + PTR_W'(1);
                  end
               end
            end
            ST_WAIT: begin
               if (!busy)
                  state <= (lvl == LVL_W'(LVLS)) ? ST_OUT : ST_TREE;
            end
            ST_TREE: begin
               if (int'(idx) + LANES >= nadds) begin
                  state <= ST_WAIT;
                  lvl   <= lvl + LVL_W'(1);
                  idx   <= '0;
               end else begin
                  idx <= idx + CNT_W'(LANES);
               end
            end
            ST_OUT: begin
               if (out_ready) state <= ST_ACC;
            end
            default: state <= ST_ACC;
         endcase
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         red_lane_pipe #(
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W),
            .STAGES (STAGES)
         ) u_pipe (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss_valid (iss_v[l]),
            .iss_idx   (iss_i[l]),
            .iss_a     (iss_a[l]),
            .iss_b     (iss_b[l]),
            .wb_valid  (wb_v[l]),
            .wb_idx    (wb_i[l]),
            .wb_data   (wb_d[l]),
            .busy      (lane_busy[l])
         );
      end
   endgenerate

   red_acc_bank #(
      .DATA_W (DATA_W),
      .NACC   (NACC),
      .LANES  (LANES),
      .IDX_W  (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (out_valid && out_ready),
      .wb_valid (wb_v),
      .wb_idx   (wb_i),
      .wb_data  (wb_d),
      .acc_q    (acc_q)
   );
endmodule

// File: rtl/red_sum_interleave_chk.sv
module red_sum_interleave_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_last,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_sum
);
   assert_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_last) |=> in_ready);

   assert_close_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);

   assert_closed_while_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

   assert_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

bind red_sum_interleave red_sum_interleave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_sum   (out_sum)
);

// File: tb/red_sum_interleave_bench.sv
`timescale 1ns/1ps
module red_sum_interleave_bench;
   localparam int W     = 32;
   localparam int LANES = 2;
   localparam int NV    = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_last = 1'b0;
   logic [LANES*W-1:0] in_ops = '0;
   logic             out_ready = 1'b0;
   logic             in_ready;
   logic             out_valid;
   logic [W-1:0]     out_sum;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   red_sum_interleave #(.DATA_W(W), .LAT(4), .LANES(LANES)) u_red_sum_interleave (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_last   (in_last),
      .in_ops    (in_ops),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_sum   (out_sum)
   );

   // {beats, base, step, expected total, idle gaps}; operand i = base + step*i
   typedef struct packed {
      logic [31:0] len;
      logic [31:0] base;
      logic [31:0] step;
      logic [31:0] expv;
      logic        gap;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{32'd1,  32'd5,          32'd2, 32'd12,          1'b0},
      '{32'd4,  32'd1,          32'd1, 32'd36,          1'b0},
      '{32'd5,  32'd0,          32'd1, 32'd45,          1'b0},
      '{32'd8,  32'd100,        32'd0, 32'd1600,        1'b0},
      '{32'd3,  32'hFFFF_FFFF,  32'd0, 32'hFFFF_FFFA,   1'b0},
      '{32'd13, 32'd10,         32'd3, 32'd1235,        1'b0},
      '{32'd2,  32'h8000_0000,  32'd0, 32'd0,           1'b0},
      '{32'd9,  32'd2,          32'd2, 32'd342,         1'b0},
      '{32'd6,  32'd7,          32'd5, 32'd414,         1'b1}
   };

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic run_stream(input vec_t v, input int vi);
      int stalls = 0;
      int opened = 0;
      int lat = 0;
      for (int k = 0; k < int'(v.len); k++) begin
         if (v.gap && (k % 2 == 1)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_ops   = {LANES*W{1'b1}};
            @(posedge clk);
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_last  = (k == int'(v.len) - 1);
         for (int l = 0; l < LANES; l++)
            in_ops[l*W +: W] = v.base + v.step * 32'(2*k + l);
         if (!in_ready) stalls++;
         @(posedge clk);
      end
      // combine phase: keep offering junk, it must not be taken (R5)
      forever begin
         @(negedge clk);
         if (out_valid || lat > 200) break;
         if (in_ready) opened++;
         in_valid = 1'b1;
         in_last  = 1'b0;
         in_ops   = {2{32'h1234_5678}};
         @(posedge clk);
         lat++;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      check(stalls == 0, $sformatf("R3 vec%0d in_ready every beat", vi), 32'(stalls), 32'd0);
      check(opened == 0, $sformatf("R5 vec%0d closed during combine", vi), 32'(opened), 32'd0);
      check(lat == 20, $sformatf("R9 vec%0d result latency", vi), 32'(lat), 32'd20);
      check(out_sum == v.expv, $sformatf("R2 R4 R8 vec%0d total", vi), out_sum, v.expv);
      // hold result back two cycles (R6)
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(out_valid && out_sum == v.expv, $sformatf("R6 vec%0d held result", vi),
            out_sum, v.expv);
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      check(in_ready && !out_valid, $sformatf("R7 vec%0d reopen after take", vi),
            {30'd0, in_ready, out_valid}, 32'd2);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready && !out_valid, "R1 idle after reset",
            {30'd0, in_ready, out_valid}, 32'd2);
      // table walk; consecutive streams also prove the clear of R7
      for (int i = 0; i < NV; i++) run_stream(VECS[i], i);
      // directed: a total that must not include the prior stream (R7)
      run_stream('{32'd1, 32'd0, 32'd0, 32'd0, 1'b0}, 99);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule